// File: doc/BRIEF.md
# Banked Display Memory Window Translator

This block lets a host that sees only a 64 KB display-memory aperture reach a larger linear video memory. Two programmable bank offset registers, A and B, each name a window base at 4 KB granularity. For every host access, the block picks one of the two banks and adds its base to the host offset within the aperture. It then issues a single read or write strobe on the memory side, carrying the resulting linear address.

A mode bit decides how the two banks are paired. With the bit set, bank A serves every read and bank B serves every write, so a copy between two regions of video memory needs no reprogramming between the read and the write. With the bit clear, the aperture splits into two 32 KB halves: the lower half is served by bank B and the upper half by bank A, so two independent windows are visible at the same time. Bank A carries one extra high bit, loaded through its own register select, so it can reach the top of the 2 MB linear space.

Host accesses and register writes are sampled on the same clock. The translated strobe and address appear one cycle later, from registers. A register write acts on the next access cycle, never on an access sampled in the same cycle.

Top module: `bankWindowXlate`

## Requirements
- R1: The memory address equals (bank << 12) + host offset, truncated to 21 bits. Any carry beyond bit 20 is discarded, and memAddr[11:0] always equals the host offset's bits 11:0.
- R2: With the mode bit at 1, every read uses bank A and every write uses bank B, whatever the host offset.
- R3: With the mode bit at 0, host offsets with bit 15 = 0 use bank B and offsets with bit 15 = 1 use bank A, for both reads and writes.
- R4: Bank A is 9 bits wide. regSel = 0 loads bits 7:0 from regData. regSel = 3 loads bit 8 from regData[0]. Each of these writes leaves the other part of bank A unchanged.
- R5: Bank B is 8 bits wide and is loaded from regData with regSel = 1.
- R6: After reset, both banks and the mode bit are 0, so the memory address equals the host offset, and no memory strobe is active.
- R7: An access produces a memory strobe only when hostSel is 1 and exactly one of hostRd or hostWr is 1. With hostSel at 0, with neither strobe, or with both strobes, no memory strobe is issued. memRd and memWr are never both 1.
- R8: An access sampled on a clock edge drives memRd or memWr, together with memAddr, for exactly one cycle after that edge. Cycles without an access leave memAddr unchanged.
- R9: A register write sampled on the same edge as an access does not affect that access. The write takes effect from the next access onward.
- R10: regSel = 2 loads the mode bit from regData[0]. Bits 7:1 of regData have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host cycle targets the aperture |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostAddr | input | 16 | Byte offset within the 64 KB aperture |
| regWe | input | 1 | Register write enable |
| regSel | input | 2 | Register select: 0 bank A low, 1 bank B, 2 mode, 3 bank A high bit |
| regData | input | 8 | Register write data |
| memRd | output | 1 | Memory read strobe, one cycle per access |
| memWr | output | 1 | Memory write strobe, one cycle per access |
| memAddr | output | 21 | Translated linear memory address |

## Verification
The bench targets the half boundary at offsets 7FFFh and 8000h in split mode. A design that tested the wrong offset bit, or swapped the banks, would send one of these offsets into the wrong window. It also targets reads and writes to the same offset in direction mode, which catch a design that decodes the half even when the direction should win. The carry case uses bank A at its full 9-bit value with offset FFFFh: a design that kept the carry, or that dropped the ninth bank bit, returns a different address. Register writes that coincide with an access, accesses with both strobes or no select, and idle cycles check the write-to-use ordering, the strobe qualification and the address hold.

// File: rtl/bwx_pkg.sv
package bwx_pkg;

  // Register select codes on the register-write port
  typedef enum logic [1:0] {
    REG_BANK_A_LO = 2'd0,
    REG_BANK_B    = 2'd1,
    REG_MODE      = 2'd2,
    REG_BANK_A_HI = 2'd3
  } regSel_e;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic ldBankALo;
    logic ldBankAHi;
    logic ldBankB;
    logic accRd;
    logic accWr;
    logic useBankA;
  } xlateStrobe_t;

endpackage

// File: rtl/bwxControl.sv
module bwxControl
  import bwx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostSel,
  input  logic         hostRd,
  input  logic         hostWr,
  input  logic         hostUpperHalf,
  input  logic         regWe,
  input  logic [1:0]   regSel,
  input  logic         regDataLsb,
  output xlateStrobe_t strb
);

  logic splitByDir;
  logic accessOk;
  regSel_e selCode;

  assign selCode  = regSel_e'(regSel);
  assign accessOk = hostSel && (hostRd != hostWr);

  // Mode bit: 1 pairs banks by direction, 0 by aperture half
  always_ff @(posedge clk) begin
    if (!rstN) begin
      splitByDir <= 1'b0;
    end else if (regWe && selCode == REG_MODE) begin
      splitByDir <= regDataLsb;
    end
  end

  always_comb begin
    strb           = '0;
    strb.ldBankALo = regWe && (selCode == REG_BANK_A_LO);
    strb.ldBankAHi = regWe && (selCode == REG_BANK_A_HI);
    strb.ldBankB   = regWe && (selCode == REG_BANK_B);
    strb.accRd     = accessOk && hostRd;
    strb.accWr     = accessOk && hostWr;
    if (splitByDir) begin
      strb.useBankA = hostRd;
    end else begin
      strb.useBankA = hostUpperHalf;
    end
  end

  AST_ACC_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accRd && strb.accWr)); // R7

endmodule

// File: rtl/bwxDatapath.sv
module bwxDatapath
  import bwx_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int MEM_AW     = 21,
  parameter int BANK_W     = 8,
  parameter int GRAN_SHIFT = 12,
  parameter int EXT_BANK_A = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  xlateStrobe_t       strb,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [BANK_W-1:0]  regData,
  output logic               memRd,
  output logic               memWr,
  output logic [MEM_AW-1:0]  memAddr
);

  localparam int BANK_A_W = BANK_W + EXT_BANK_A;

  logic [BANK_W-1:0]   bankALo;
  logic [BANK_W-1:0]   bankB;
  logic [BANK_A_W-1:0] bankA;
  logic [BANK_A_W-1:0] bankSel;
  logic [MEM_AW-1:0]   windowBase;
  logic [MEM_AW-1:0]   nextAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankALo <= '0;
      bankB   <= '0;
    end else begin
      if (strb.ldBankALo) bankALo <= regData;
      if (strb.ldBankB)   bankB   <= regData;
    end
  end

  generate
    if (EXT_BANK_A != 0) begin : gExtBank
      logic bankAHi;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bankAHi <= 1'b0;
        end else if (strb.ldBankAHi) begin
          bankAHi <= regData[0];
        end
      end
      assign bankA = {bankAHi, bankALo};
    end else begin : gBaseBank
      assign bankA = bankALo;
    end
  endgenerate

  // Bank added at 4 KB granularity; carry past the top bit is dropped
  assign bankSel    = strb.useBankA ? bankA : BANK_A_W'(bankB);
  assign windowBase = MEM_AW'(bankSel) << GRAN_SHIFT;
  assign nextAddr   = windowBase + MEM_AW'(hostAddr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRd   <= 1'b0;
      memWr   <= 1'b0;
      memAddr <= '0;
    end else begin
      memRd <= strb.accRd;
      memWr <= strb.accWr;
      if (strb.accRd || strb.accWr) begin
        memAddr <= nextAddr;
      end
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accRd || strb.accWr) |=> $stable(memAddr)); // R8

endmodule

// File: rtl/bankWindowXlate.sv
module bankWindowXlate
  import bwx_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int MEM_AW     = 21,
  parameter int BANK_W     = 8,
  parameter int GRAN_SHIFT = 12,
  parameter int EXT_BANK_A = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostRd,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               regWe,
  input  logic [1:0]         regSel,
  input  logic [BANK_W-1:0]  regData,
  output logic               memRd,
  output logic               memWr,
  output logic [MEM_AW-1:0]  memAddr
);

  xlateStrobe_t strb;

  bwxControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostSel      (hostSel),
    .hostRd       (hostRd),
    .hostWr       (hostWr),
    .hostUpperHalf(hostAddr[HOST_AW-1]),
    .regWe        (regWe),
    .regSel       (regSel),
    .regDataLsb   (regData[0]),
    .strb         (strb)
  );

  bwxDatapath #(
    .HOST_AW   (HOST_AW),
    .MEM_AW    (MEM_AW),
    .BANK_W    (BANK_W),
    .GRAN_SHIFT(GRAN_SHIFT),
    .EXT_BANK_A(EXT_BANK_A)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .hostAddr(hostAddr),
    .regData (regData),
    .memRd   (memRd),
    .memWr   (memWr),
    .memAddr (memAddr)
  );

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R7

  AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !hostSel |=> !(memRd || memWr)); // R7

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) |-> memAddr[GRAN_SHIFT-1:0] == $past(hostAddr[GRAN_SHIFT-1:0])); // R1

endmodule

// File: tb/sim_bankWindowXlate.sv
`timescale 1ns/1ps
module sim_bankWindowXlate;

  typedef struct {
    logic        rd;
    logic        wr;
    logic [20:0] addr;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [7:0]  regData = '0;
  logic        memRd;
  logic        memWr;
  logic [20:0] memAddr;

  int nChecks = 0;
  int nFail = 0;

  // Reference model state
  logic [8:0]  mBankA = '0;
  logic [7:0]  mBankB = '0;
  logic        mMode = 1'b0;
  logic [20:0] mLast = '0;

  expItem_t sbQ[$];
  expItem_t popped;

  always #2.5 clk = ~clk;

  bankWindowXlate u0 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRd(hostRd), .hostWr(hostWr),
    .hostAddr(hostAddr), .regWe(regWe), .regSel(regSel), .regData(regData),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr)
  );

  task automatic check(input bit ok, input string tag, input string got, input string exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %s expected %s", tag, got, exp);
    end
  endtask

  // Driver: one host cycle plus optional register write; pushes expected result
  task automatic drive(input logic s, input logic r, input logic w, input logic [15:0] a,
                       input logic we, input logic [1:0] rs, input logic [7:0] d,
                       input string tag);
    expItem_t it;
    logic useA;
    logic [20:0] base;
    @(negedge clk);
    hostSel = s; hostRd = r; hostWr = w; hostAddr = a;
    regWe = we; regSel = rs; regData = d;
    it.tag = tag;
    it.rd = s && r && !w;
    it.wr = s && w && !r;
    useA = mMode ? r : a[15];
    base = useA ? {mBankA, 12'h000} : {1'b0, mBankB, 12'h000};
    if (it.rd || it.wr) mLast = base + {5'd0, a};
    it.addr = mLast;
    sbQ.push_back(it);
    if (we) begin
      case (rs)
        2'd0: mBankA[7:0] = d;
        2'd1: mBankB = d;
        2'd2: mMode = d[0];
        default: mBankA[8] = d[0];
      endcase
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    drive(1, 1, 0, a, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic [15:0] a, input string tag);
    drive(1, 0, 1, a, 0, 0, 0, tag);
  endtask

  task automatic setReg(input logic [1:0] rs, input logic [7:0] d, input string tag);
    drive(0, 0, 0, 16'h0, 1, rs, d, tag);
  endtask

  // Monitor: pops one expectation per cycle, after the edge that produced it
  always @(posedge clk) begin
    if (rstN) begin
      #1;
      if (sbQ.size() > 0) begin
        popped = sbQ.pop_front();
        check(memRd === popped.rd && memWr === popped.wr && memAddr === popped.addr,
              popped.tag,
              $sformatf("rd=%b wr=%b addr=%06h", memRd, memWr, memAddr),
              $sformatf("rd=%b wr=%b addr=%06h", popped.rd, popped.wr, popped.addr));
      end
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(memRd === 1'b0 && memWr === 1'b0 && memAddr === 21'h0, "R6 reset outputs",
          $sformatf("%b %b %06h", memRd, memWr, memAddr), "0 0 000000");
    rstN = 1'b1;

    // R6 identity after reset
    rd(16'h1234, "R6 identity read");
    wr(16'hABCD, "R6 identity write");

    // R7 strobe qualification, R8 address hold on idle
    drive(0, 1, 0, 16'h5555, 0, 0, 0, "R7 deselected read");
    drive(1, 1, 1, 16'h6666, 0, 0, 0, "R7 both strobes");
    drive(1, 0, 0, 16'h7777, 0, 0, 0, "R8 no strobe holds address");

    // R4/R5 loads, R3 split by half
    setReg(2'd0, 8'h12, "R4 load bank A low");
    setReg(2'd1, 8'h34, "R5 load bank B");
    rd(16'h0100, "R3 lower half read uses B");
    rd(16'h8100, "R3 upper half read uses A");
    wr(16'h9000, "R3 upper half write uses A");
    wr(16'h7FFF, "R3 boundary 7FFF uses B");
    rd(16'h8000, "R3 boundary 8000 uses A");

    // R10 mode load, R2 direction pairing
    setReg(2'd2, 8'h01, "R10 set mode");
    rd(16'h0010, "R2 read uses A in lower half");
    wr(16'h0010, "R2 write uses B in lower half");
    rd(16'hF000, "R2 read uses A in upper half");
    wr(16'hF000, "R2 write uses B in upper half");

    // R4 ninth bit and R1 carry discard
    setReg(2'd3, 8'h01, "R4 load bank A high bit");
    rd(16'h0004, "R4 ninth bank bit adds 1 MB");
    setReg(2'd0, 8'hFF, "R4 low load keeps high bit");
    rd(16'hFFFF, "R1 carry past bit 20 dropped");
    rd(16'h0ABC, "R1 low 12 bits pass through");

    // R9 same-cycle register write does not affect the access
    drive(1, 0, 1, 16'h0000, 1, 2'd1, 8'h50, "R9 write with coincident load uses old B");
    wr(16'h0000, "R9 next write uses new B");

    // R5 full-width bank B
    setReg(2'd1, 8'hFF, "R5 bank B all ones");
    wr(16'h0001, "R5 bank B top window");

    // R10 only bit 0 of data matters
    setReg(2'd2, 8'hFE, "R10 clear mode with upper bits set");
    rd(16'h7FFF, "R10 mode cleared lower half uses B");
    wr(16'h8000, "R10 mode cleared upper half uses A");
    setReg(2'd3, 8'hFE, "R4 high bit loads from bit 0 only");
    rd(16'h8000, "R4 high bit cleared");

    drive(0, 0, 0, 16'h0, 0, 0, 0, "R8 idle hold");
    drive(0, 0, 0, 16'h0, 0, 0, 0, "R8 idle hold");
    @(negedge clk);
    hostSel = 0; hostRd = 0; hostWr = 0; regWe = 0;
    wait (sbQ.size() == 0);
    @(negedge clk);
    finishRun();
  end

endmodule